// File: doc/BRIEF.md
# Subtract and Rotate-Through-Carry ALU Slice

This slice is the arithmetic step of a small accumulator-style processor. Each cycle in which `valid` is high, it takes the working register value, a file operand read from the register file, and an immediate literal. It then produces one result and the write enables that steer that result. It handles three subtract forms and a right rotate through the carry flag. The subtract forms are file minus working register, literal minus working register, and file minus working register minus a pending borrow.

The carry, digit-carry and zero flags live inside the slice. They are written back on the clock edge that ends the operation. For subtraction, carry acts as an inverted borrow: a value of 1 means nothing was borrowed. The digit carry is the same indication taken at the half-width boundary. The rotate feeds the old carry into the top bit and captures the bottom bit into carry.

The register file, instruction fetch and addressing sit outside the slice. The file address is echoed so that the write-back port of the file can use it directly.

Top module: `sub_rot_alu`

## Requirements
- R1: `op` encoding is 0 = file subtract, 1 = literal subtract, 2 = subtract with borrow, 3 = rotate right through carry. A literal subtract gives `lit - wreg` modulo 2^WIDTH and always raises `w_we` (never `f_we`), whatever `dest` is.
- R2: A file subtract gives `fdata - wreg` modulo 2^WIDTH on `result`.
- R3: A subtract with borrow gives `fdata - wreg - (1 - carry)` modulo 2^WIDTH, using the carry held before the operation.
- R4: After any subtract, `carry` is 1 exactly when the full-width difference, including any borrow-in, did not go below zero.
- R5: After any subtract, `dcarry` is 1 exactly when the difference of the low WIDTH/2 bits, including any borrow-in, did not go below zero.
- R6: After any subtract, `zero` is 1 exactly when that operation's WIDTH-bit result is zero.
- R7: A rotate gives `{carry, fdata[WIDTH-1:1]}` and loads `fdata[0]` into `carry`; `dcarry` and `zero` keep their values.
- R8: For operations other than the literal subtract, `dest` = 0 raises `w_we` and `dest` = 1 raises `f_we`. `f_waddr` always equals `faddr`.
- R9: While `valid` is low, `w_we` and `f_we` stay low and all three flags keep their values.
- R10: After reset, `carry`, `dcarry` and `zero` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset of the flags |
| valid | input | 1 | An operation is presented this cycle |
| op | input | 2 | Operation select |
| dest | input | 1 | 0 steers to working register, 1 to file |
| faddr | input | ADDR_W | File operand address |
| fdata | input | WIDTH | File operand value |
| lit | input | WIDTH | Immediate literal |
| wreg | input | WIDTH | Working register value |
| result | output | WIDTH | Operation result |
| w_we | output | 1 | Write result to working register |
| f_we | output | 1 | Write result back to file |
| f_waddr | output | ADDR_W | File write-back address |
| carry | output | 1 | Carry / inverted borrow flag |
| dcarry | output | 1 | Half-width carry / inverted borrow flag |
| zero | output | 1 | Zero flag |

## Verification
The bench builds the slice with WIDTH = 4 and keeps ADDR_W at 7. This makes a full sweep practical: every working register value, every operand value and both carry-in states, for all four operations and both `dest` settings. The narrow width puts every borrow case within reach, including the half-width boundary at bit 2 and the borrow that is pending on a subtract with borrow. Idle cycles with random inputs show that the flags hold.

// File: rtl/sub_rot_alu.sv
module sub_rot_alu #(
  parameter int WIDTH  = 8,
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid,
  input  logic [1:0]        op,
  input  logic              dest,
  input  logic [ADDR_W-1:0] faddr,
  input  logic [WIDTH-1:0]  fdata,
  input  logic [WIDTH-1:0]  lit,
  input  logic [WIDTH-1:0]  wreg,
  output logic [WIDTH-1:0]  result,
  output logic              w_we,
  output logic              f_we,
  output logic [ADDR_W-1:0] f_waddr,
  output logic              carry,
  output logic              dcarry,
  output logic              zero
);
  localparam int HALF = WIDTH / 2;
  localparam logic [1:0] OP_SUBF = 2'd0;
  localparam logic [1:0] OP_SUBL = 2'd1;
  localparam logic [1:0] OP_SUBB = 2'd2;
  localparam logic [1:0] OP_RRC  = 2'd3;

  logic c_q, dc_q, z_q;

  wire is_rot = (op == OP_RRC);
  wire is_lit = (op == OP_SUBL);
  wire bin    = (op == OP_SUBB) & ~c_q;

  wire [WIDTH-1:0] minu = is_lit ? lit : fdata;

  wire [WIDTH:0] full_diff = {1'b0, minu} - {1'b0, wreg} - {{WIDTH{1'b0}}, bin};
  wire [HALF:0]  low_diff  = {1'b0, minu[HALF-1:0]} - {1'b0, wreg[HALF-1:0]}
                             - {{HALF{1'b0}}, bin};

  wire [WIDTH-1:0] rot_res = {c_q, fdata[WIDTH-1:1]};

  assign result  = is_rot ? rot_res : full_diff[WIDTH-1:0];
  assign w_we    = valid & (is_lit | ~dest);
  assign f_we    = valid & ~is_lit & dest;
  assign f_waddr = faddr;
  assign carry   = c_q;
  assign dcarry  = dc_q;
  assign zero    = z_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c_q  <= 1'b0;
      dc_q <= 1'b0;
      z_q  <= 1'b0;
    end else if (valid) begin
      if (is_rot) begin
        c_q <= fdata[0];
      end else begin
        c_q  <= ~full_diff[WIDTH];
        dc_q <= ~low_diff[HALF];
        z_q  <= (full_diff[WIDTH-1:0] == '0);
      end
    end
  end

  // R1
  lit_to_w_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && is_lit) |-> (w_we && !f_we));

  // R4
  subf_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && op == OP_SUBF) |=> (carry == ($past(wreg) <= $past(fdata))));

  // R6
  zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !is_rot) |=> (zero == ($past(result) == '0)));

  // R7
  rot_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && is_rot) |=> (carry == $past(fdata[0]) && $stable(dcarry) && $stable(zero)));

  // R8
  we_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({w_we, f_we}));

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |=> ($stable(carry) && $stable(dcarry) && $stable(zero)));

  // R9
  idle_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |-> (!w_we && !f_we));
endmodule

// File: tb/sim_sub_rot_alu.sv
module sim_sub_rot_alu;
  localparam int W  = 4;
  localparam int AW = 7;
  localparam int MASK = (1 << W) - 1;
  localparam int HM   = (1 << (W / 2)) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic valid = 1'b0;
  logic [1:0] op = 2'd0;
  logic dest = 1'b0;
  logic [AW-1:0] faddr = '0;
  logic [W-1:0] fdata = '0, lit = '0, wreg = '0;
  logic [W-1:0] result;
  logic w_we, f_we, carry, dcarry, zero;
  logic [AW-1:0] f_waddr;

  int checks = 0;
  int fails = 0;
  int mc = 0, mdc = 0, mz = 0;

  always #2.5 clk = ~clk;

  sub_rot_alu #(.WIDTH(W), .ADDR_W(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .valid(valid), .op(op), .dest(dest),
    .faddr(faddr), .fdata(fdata), .lit(lit), .wreg(wreg),
    .result(result), .w_we(w_we), .f_we(f_we), .f_waddr(f_waddr),
    .carry(carry), .dcarry(dcarry), .zero(zero)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (op=%0d f=%0d l=%0d w=%0d)",
               tag, act, exp, op, fdata, lit, wreg);
    end
  endtask

  task automatic run_op(input int o, input int d, input int f, input int l, input int w);
    int m, bi, diff, lo, res, ewe, efe;
    @(negedge clk);
    valid = 1'b1; op = o[1:0]; dest = d[0]; fdata = f[W-1:0]; lit = l[W-1:0];
    wreg = w[W-1:0]; faddr = AW'((f * 37 + l) & 127);
    #1;
    if (o == 3) begin
      res = ((mc << (W - 1)) | (f >> 1)) & MASK;
      chk("R7 result", int'(result), res);
    end else begin
      m = (o == 1) ? l : f;
      bi = (o == 2) ? (1 - mc) : 0;
      diff = m - w - bi;
      lo = (m & HM) - (w & HM) - bi;
      res = diff & MASK;
      if (o == 0) chk("R2 result", int'(result), res);
      else if (o == 1) chk("R1 result", int'(result), res);
      else chk("R3 result", int'(result), res);
      mdc = (lo >= 0);
      mz = (res == 0);
    end
    ewe = (o == 1) ? 1 : (d == 0);
    efe = (o == 1) ? 0 : (d == 1);
    if (o == 1) chk("R1 w_we", int'(w_we), 1);
    chk("R8 w_we", int'(w_we), ewe);
    chk("R8 f_we", int'(f_we), efe);
    chk("R8 f_waddr", int'(f_waddr), int'(faddr));
    if (o == 3) mc = f & 1;
    else mc = (diff >= 0);
    @(posedge clk); #1;
    if (o == 3) chk("R7 carry", int'(carry), mc);
    else chk("R4 carry", int'(carry), mc);
    chk("R5 dcarry", int'(dcarry), mdc);
    chk("R6 zero", int'(zero), mz);
  endtask

  initial begin
    int wd = 0;
    forever begin
      @(posedge clk);
      wd++;
      if (wd > 150000) begin
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R10 carry", int'(carry), 0);
    chk("R10 dcarry", int'(dcarry), 0);
    chk("R10 zero", int'(zero), 0);
    chk("R9 w_we", int'(w_we), 0);
    @(negedge clk);
    rst_n = 1'b1;
    for (int o = 0; o < 4; o++)
      for (int d = 0; d < 2; d++)
        for (int w = 0; w <= MASK; w++)
          for (int x = 0; x <= MASK; x++)
            for (int ci = 0; ci < 2; ci++) begin
              run_op(3, d, ci, 0, 0);
              run_op(o, d, x, (x * 5 + 3) & MASK, w);
              if (o == 1) run_op(o, d, 0, x, w);
            end
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      valid = 1'b0; op = 2'($urandom); dest = 1'($urandom);
      fdata = W'($urandom); lit = W'($urandom); wreg = W'($urandom);
      #1;
      chk("R9 w_we idle", int'(w_we), 0);
      chk("R9 f_we idle", int'(f_we), 0);
      @(posedge clk); #1;
      chk("R9 carry hold", int'(carry), mc);
      chk("R9 dcarry hold", int'(dcarry), mdc);
      chk("R9 zero hold", int'(zero), mz);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule